// File: doc/BRIEF.md
# Single-Precision Result Packer

This block turns an unpacked floating-point value into a 32-bit IEEE-754 single-precision word. The input value has four parts: a class code, a sign, a two's-complement unbiased exponent, and a wide normalised mantissa that carries its leading 1 in the top bit. A separate sticky bit holds any precision that was lost upstream. The block rounds that value in one of four directed modes, forms normal or subnormal encodings, and handles special classes. On overflow it saturates as the rounding mode selects. It also reports inexact, underflow and overflow flags.

A subnormal result is shifted right before rounding, so that the rounding step sees the bits that will really be discarded. Such a result may round up into the smallest normal number. A normal significand that rounds up to 2.0 moves the exponent up by one. The packed word and the flags are registered, so they appear one clock after the inputs are applied.

Top module: `sp_packer`

## Requirements
- R1: Class code 0 (zero) gives a word with the input sign in bit 31, all other bits 0, and no flag set.
- R2: Class code 2 (infinity) gives the input sign, exponent field 255 (bits 30:23) and a zero fraction (bits 22:0), with no flag set.
- R3: Class code 3 (NaN) gives the input sign and exponent field 255. Fraction bits 21:0 are the mantissa bits that sit directly below its top two bits. Fraction bit 22 is always 1, even for a signalling NaN. No flag is set.
- R4: For class code 1 (number), the biased exponent is the input exponent plus 127. When that sum is at least 1, the result is normal. The 24-bit significand is taken from the top 24 mantissa bits, and the next two bits are guard and round. The remaining bits, ORed with the sticky input, form the sticky. The fraction field is the low 23 bits of the rounded significand, with the implied 1 dropped.
- R5: Mode code 0 rounds to nearest, with ties going to even. Code 1 rounds toward zero. Code 2 rounds toward plus infinity and code 3 toward minus infinity. The inexact flag is set whenever guard, round or sticky is nonzero.
- R6: On the normal path, a significand that rounds up to 2.0 increments the exponent field and leaves a zero fraction.
- R7: When the biased exponent is 0 or less, the mantissa is shifted right by an extra (1 - biased exponent) places before rounding. The exponent field is then 0. If rounding carries into bit 23, the result is the smallest normal number: exponent 1, fraction 0.
- R8: The underflow flag is set exactly when a number stays subnormal or becomes zero on the subnormal path, and the result was either inexact or the underflow-trap-enable input was high.
- R9: On the normal path, an exponent of 255 or more after rounding is an overflow. The result is infinity in mode 0, in mode 2 for a positive value, and in mode 3 for a negative value. In every other case it is the largest finite value (exponent 254, fraction all ones). Overflow and inexact are both set.
- R10: The word and the flags are registered, and they change only on the clock edge that follows the inputs. The asynchronous active-low reset clears all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| class_i | input | 2 | Value class: 0 zero, 1 number, 2 infinity, 3 NaN |
| sign_i | input | 1 | Sign of the value |
| exp_i | input | EXP_W | Unbiased exponent, two's complement |
| mant_i | input | MANT_W | Normalised mantissa with leading 1 at the top bit |
| sticky_i | input | 1 | Precision already lost below the mantissa |
| mode_i | input | 2 | Rounding mode: 0 nearest-even, 1 toward zero, 2 toward plus infinity, 3 toward minus infinity |
| uf_trap_en_i | input | 1 | Underflow trap enable |
| result_o | output | 32 | Packed single-precision word |
| inexact_o | output | 1 | Result was rounded or saturated |
| underflow_o | output | 1 | Tiny result under the rule of R8 |
| overflow_o | output | 1 | Exponent range exceeded |

## Verification
Every output of this block is due exactly one rising edge after the inputs are applied, because the whole path from the inputs to the output register is combinational. The bench changes the inputs on a falling edge. Just before the next rising edge it confirms that the outputs still hold the previous vector's result. It then compares the new word and all three flags on the following falling edge. The expected values come from a real-number model that scales the exact value to its unit in the last place, for all four modes, both signs and both trap settings. The sweep covers exponents across the subnormal boundary and the overflow boundary, and includes the largest subnormal and tie patterns.

// File: rtl/sp_pack_pkg.sv
package sp_pack_pkg;
  typedef enum logic [1:0] {
    CLS_ZERO = 2'd0,
    CLS_NUM  = 2'd1,
    CLS_INF  = 2'd2,
    CLS_NAN  = 2'd3
  } val_class_e;

  typedef enum logic [1:0] {
    RND_NEAREST = 2'd0,
    RND_ZERO    = 2'd1,
    RND_POS     = 2'd2,
    RND_NEG     = 2'd3
  } rnd_mode_e;

  localparam int SIG_W   = 24;
  localparam int FRAC_W  = SIG_W - 1;
  localparam int EXPF_W  = 8;
  localparam int BIAS    = 127;
  localparam int EXP_TOP = (1 << EXPF_W) - 1;
  localparam int WORD_W  = 1 + EXPF_W + FRAC_W;
endpackage

// File: rtl/sp_pack_align.sv
module sp_pack_align
  import sp_pack_pkg::*;
#(
  parameter int MANT_W = 32,
  parameter int SH_W   = $clog2(MANT_W + 1)
) (
  input  logic [MANT_W-1:0] mant_i,
  input  logic              sticky_i,
  input  logic [SH_W-1:0]   shamt_i,
  output logic [SIG_W-1:0]  sig_o,
  output logic              guard_o,
  output logic              round_o,
  output logic              sticky_o
);
  localparam int TAIL_W = MANT_W - SIG_W - 2;

  logic [MANT_W-1:0] shifted;
  logic [MANT_W-1:0] lost_mask;
  logic              lost;
  logic              tail_or;

  always_comb begin
    shifted   = mant_i >> shamt_i;
    lost_mask = ~({MANT_W{1'b1}} << shamt_i);
    lost      = |(mant_i & lost_mask);
  end

  generate
    if (TAIL_W > 0) begin : g_tail
      assign tail_or = |shifted[TAIL_W-1:0];
    end else begin : g_no_tail
      assign tail_or = 1'b0;
    end
  endgenerate

  assign sig_o    = shifted[MANT_W-1 -: SIG_W];
  assign guard_o  = shifted[MANT_W-SIG_W-1];
  assign round_o  = shifted[MANT_W-SIG_W-2];
  assign sticky_o = tail_or | lost | sticky_i;
endmodule

// File: rtl/sp_pack_round.sv
module sp_pack_round
  import sp_pack_pkg::*;
(
  input  logic [SIG_W-1:0] sig_i,
  input  logic             guard_i,
  input  logic             round_i,
  input  logic             sticky_i,
  input  rnd_mode_e        mode_i,
  input  logic             sign_i,
  output logic [SIG_W:0]   sig_o,
  output logic             inexact_o
);
  logic up;

  always_comb begin
    inexact_o = guard_i | round_i | sticky_i;
    unique case (mode_i)
      RND_NEAREST: up = guard_i & (round_i | sticky_i | sig_i[0]);
      RND_ZERO:    up = 1'b0;
      RND_POS:     up = inexact_o & ~sign_i;
      RND_NEG:     up = inexact_o & sign_i;
      default:     up = 1'b0;
    endcase
    sig_o = {1'b0, sig_i} + {{SIG_W{1'b0}}, up};
  end
endmodule

// File: rtl/sp_pack_ovf.sv
module sp_pack_ovf
  import sp_pack_pkg::*;
(
  input  rnd_mode_e         mode_i,
  input  logic              sign_i,
  output logic [WORD_W-2:0] sat_o
);
  logic to_inf;

  always_comb begin
    unique case (mode_i)
      RND_NEAREST: to_inf = 1'b1;
      RND_ZERO:    to_inf = 1'b0;
      RND_POS:     to_inf = ~sign_i;
      RND_NEG:     to_inf = sign_i;
      default:     to_inf = 1'b1;
    endcase
    if (to_inf) sat_o = {EXPF_W'(EXP_TOP), {FRAC_W{1'b0}}};
    else        sat_o = {EXPF_W'(EXP_TOP - 1), {FRAC_W{1'b1}}};
  end
endmodule

// File: rtl/sp_packer.sv
module sp_packer
  import sp_pack_pkg::*;
#(
  parameter int EXP_W  = 10,
  parameter int MANT_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        class_i,
  input  logic              sign_i,
  input  logic [EXP_W-1:0]  exp_i,
  input  logic [MANT_W-1:0] mant_i,
  input  logic              sticky_i,
  input  logic [1:0]        mode_i,
  input  logic              uf_trap_en_i,
  output logic [31:0]       result_o,
  output logic              inexact_o,
  output logic              underflow_o,
  output logic              overflow_o
);
  localparam int BEXP_W = EXP_W + 2;
  localparam int SH_W   = $clog2(MANT_W + 1);

  val_class_e cls;
  rnd_mode_e  mode;
  assign cls  = val_class_e'(class_i);
  assign mode = rnd_mode_e'(mode_i);

  // biased exponent and subnormal shift distance
  logic signed [BEXP_W-1:0] bexp;
  logic signed [BEXP_W:0]   sub_dist;
  logic signed [BEXP_W:0]   e_norm;
  logic                     sub;
  logic [SH_W-1:0]          shamt;

  always_comb begin
    bexp     = {{2{exp_i[EXP_W-1]}}, exp_i} + BEXP_W'(BIAS);
    sub      = (bexp <= 0);
    sub_dist = (BEXP_W+1)'(1) - {bexp[BEXP_W-1], bexp};
    if (!sub)                 shamt = '0;
    else if (sub_dist > MANT_W) shamt = SH_W'(MANT_W);
    else                      shamt = SH_W'(sub_dist);
  end

  logic [SIG_W-1:0] a_sig;
  logic             a_guard, a_round, a_sticky;

  sp_pack_align #(.MANT_W(MANT_W), .SH_W(SH_W)) u_align (
    .mant_i   (mant_i),
    .sticky_i (sticky_i),
    .shamt_i  (shamt),
    .sig_o    (a_sig),
    .guard_o  (a_guard),
    .round_o  (a_round),
    .sticky_o (a_sticky)
  );

  logic [SIG_W:0] r_sig;
  logic           r_inexact;

  sp_pack_round u_round (
    .sig_i     (a_sig),
    .guard_i   (a_guard),
    .round_i   (a_round),
    .sticky_i  (a_sticky),
    .mode_i    (mode),
    .sign_i    (sign_i),
    .sig_o     (r_sig),
    .inexact_o (r_inexact)
  );

  logic [WORD_W-2:0] sat_word;

  sp_pack_ovf u_ovf (
    .mode_i (mode),
    .sign_i (sign_i),
    .sat_o  (sat_word)
  );

  logic [31:0] word_d;
  logic        nx_d, uf_d, of_d, ovf;

  always_comb begin
    e_norm = {bexp[BEXP_W-1], bexp} + {{BEXP_W{1'b0}}, r_sig[SIG_W]};
    ovf    = !sub && (e_norm >= $signed((BEXP_W+1)'(EXP_TOP)));
    word_d = '0;
    nx_d   = 1'b0;
    uf_d   = 1'b0;
    of_d   = 1'b0;
    unique case (cls)
      CLS_ZERO: word_d = {sign_i, 31'd0};
      CLS_INF:  word_d = {sign_i, EXPF_W'(EXP_TOP), {FRAC_W{1'b0}}};
      CLS_NAN:  word_d = {sign_i, EXPF_W'(EXP_TOP), 1'b1, mant_i[MANT_W-3 -: FRAC_W-1]};
      CLS_NUM: begin
        if (sub) begin
          // carry into bit 23 lands on exponent 1, fraction 0
          word_d = {sign_i, {(EXPF_W-1){1'b0}}, r_sig[FRAC_W], r_sig[FRAC_W-1:0]};
          nx_d   = r_inexact;
          uf_d   = ~r_sig[FRAC_W] & (r_inexact | uf_trap_en_i);
        end else if (ovf) begin
          word_d = {sign_i, sat_word};
          nx_d   = 1'b1;
          of_d   = 1'b1;
        end else begin
          word_d = {sign_i, e_norm[EXPF_W-1:0], r_sig[FRAC_W-1:0]};
          nx_d   = r_inexact;
        end
      end
      default: word_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o    <= '0;
      inexact_o   <= 1'b0;
      underflow_o <= 1'b0;
      overflow_o  <= 1'b0;
    end else begin
      result_o    <= word_d;
      inexact_o   <= nx_d;
      underflow_o <= uf_d;
      overflow_o  <= of_d;
    end
  end
endmodule

// File: rtl/sp_packer_chk.sv
module sp_packer_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [1:0]  class_i,
  input logic        sign_i,
  input logic [1:0]  mode_i,
  input logic        uf_trap_en_i,
  input logic [31:0] result_o,
  input logic        inexact_o,
  input logic        underflow_o,
  input logic        overflow_o
);
  a_r1_zero_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    class_i == 2'd0 |=> result_o[30:0] == 31'd0 && !inexact_o && !underflow_o && !overflow_o);

  a_r2_inf_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    class_i == 2'd2 |=> result_o[30:0] == 31'h7F80_0000 && !inexact_o && !underflow_o && !overflow_o);

  a_r3_nan_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    class_i == 2'd3 |=> result_o[30:22] == 9'h1FF && !inexact_o && !underflow_o && !overflow_o);

  a_r10_sign_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> result_o[31] == $past(sign_i));

  a_r8_uf_is_tiny: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underflow_o |-> result_o[30:23] == 8'd0);

  a_r8_uf_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underflow_o |-> inexact_o || $past(uf_trap_en_i));

  a_r9_ovf_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |-> inexact_o &&
      (result_o[30:0] == 31'h7F80_0000 || result_o[30:0] == 31'h7F7F_FFFF));

  a_r9_rz_no_inf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (class_i == 2'd1 && mode_i == 2'd1) |=> result_o[30:23] != 8'hFF);
endmodule

bind sp_packer sp_packer_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .class_i      (class_i),
  .sign_i       (sign_i),
  .mode_i       (mode_i),
  .uf_trap_en_i (uf_trap_en_i),
  .result_o     (result_o),
  .inexact_o    (inexact_o),
  .underflow_o  (underflow_o),
  .overflow_o   (overflow_o)
);

// File: tb/sp_packer_tb.sv
module sp_packer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int EXP_W      = 10;
  localparam int MANT_W     = 32;
  localparam int WDOG       = 150000;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [1:0]        class_i = '0;
  logic              sign_i = 1'b0;
  logic [EXP_W-1:0]  exp_i = '0;
  logic [MANT_W-1:0] mant_i = '0;
  logic              sticky_i = 1'b0;
  logic [1:0]        mode_i = '0;
  logic              uf_trap_en_i = 1'b0;
  logic [31:0]       result_o;
  logic              inexact_o, underflow_o, overflow_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [31:0] prev_res = '0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  sp_packer #(.EXP_W(EXP_W), .MANT_W(MANT_W)) u_dut (
    .clk_i, .rst_ni, .class_i, .sign_i, .exp_i, .mant_i, .sticky_i,
    .mode_i, .uf_trap_en_i, .result_o, .inexact_o, .underflow_o, .overflow_o
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // real-number model: scale the exact value to units of the last place
  task automatic ref_pack(input logic [1:0] cls, input logic sgn, input int e,
                          input logic [31:0] m, input logic stk, input logic [1:0] md,
                          input logic ufe, output logic [31:0] res,
                          output logic nx, output logic uf, output logic of,
                          output string tag);
    int     ulp_e, be;
    real    scaled, rem;
    longint q;
    logic   up, inx, tiny, to_inf;
    res = {sgn, 31'd0}; nx = 0; uf = 0; of = 0;
    case (cls)
      2'd0: tag = "R1";
      2'd2: begin tag = "R2"; res = {sgn, 8'hFF, 23'd0}; end
      2'd3: begin tag = "R3"; res = {sgn, 8'hFF, 1'b1, m[29:8]}; end
      default: begin
        tiny   = (e < -126);
        ulp_e  = tiny ? -149 : e - 23;
        scaled = real'(m) * (2.0 ** (e - 31 - ulp_e));
        q      = longint'($floor(scaled));
        rem    = scaled - real'(q);
        inx    = (rem != 0.0) || stk;
        case (md)
          2'd0:    up = (rem > 0.5) || (rem == 0.5 && (stk || q[0]));
          2'd1:    up = 1'b0;
          2'd2:    up = inx && !sgn;
          default: up = inx && sgn;
        endcase
        q  = q + (up ? 1 : 0);
        nx = inx;
        if (tiny) begin
          tag = "R7";
          if (q == 64'd8388608) res = {sgn, 8'd1, 23'd0};
          else begin
            res = {sgn, 8'd0, q[22:0]};
            uf  = inx || ufe;
          end
        end else begin
          be  = e + 127;
          tag = "R4";
          if (q == 64'd16777216) begin be++; q = 64'd8388608; tag = "R6"; end
          if (be >= 255) begin
            tag    = "R9";
            of     = 1; nx = 1;
            to_inf = (md == 2'd0) || (md == 2'd2 && !sgn) || (md == 2'd3 && sgn);
            res    = to_inf ? {sgn, 8'hFF, 23'd0} : {sgn, 8'hFE, 23'h7FFFFF};
          end else res = {sgn, 8'(be), q[22:0]};
        end
      end
    endcase
  endtask

  task automatic run_vec(input logic [1:0] cls, input logic sgn, input int e,
                         input logic [31:0] m, input logic stk, input logic [1:0] md,
                         input logic ufe);
    logic [31:0] r; logic nx, uf, of; string tag;
    @(negedge clk_i);
    class_i = cls; sign_i = sgn; exp_i = EXP_W'(e); mant_i = m;
    sticky_i = stk; mode_i = md; uf_trap_en_i = ufe;
    #1;
    check("R10 hold before edge", result_o, prev_res);
    @(negedge clk_i);
    ref_pack(cls, sgn, e, m, stk, md, ufe, r, nx, uf, of, tag);
    check(tag, result_o, r);
    check("R5 inexact", 32'(inexact_o), 32'(nx));
    check("R8 underflow", 32'(underflow_o), 32'(uf));
    check("R9 overflow", 32'(overflow_o), 32'(of));
    prev_res = r;
  endtask

  function automatic logic [31:0] pattern(input int k);
    case (k)
      0:  return 32'h8000_0000;
      1:  return 32'hFFFF_FFFF;
      2:  return 32'h8000_0080;
      3:  return 32'h8000_0180;
      4:  return 32'h8000_00C0;
      5:  return 32'h8000_0040;
      6:  return 32'h8000_0001;
      7:  return 32'hFFFF_FF80;
      8:  return 32'hFFFF_FF7F;
      9:  return 32'hFFFF_FE00;
      10: return 32'hAAAA_AAAA;
      default: return 32'h8000_017F;
    endcase
  endfunction

  initial begin
    logic [31:0] lfsr;
    #(3*CLK_PERIOD);
    check("R10 reset word", result_o, 32'd0);
    check("R10 reset flags", {29'd0, inexact_o, underflow_o, overflow_o}, 32'd0);
    rst_ni = 1'b1;

    // special classes
    for (int s = 0; s < 2; s++) begin
      run_vec(2'd0, s[0], 0, 32'h0, 1'b1, 2'd2, 1'b1);
      run_vec(2'd2, s[0], 0, 32'h0, 1'b0, 2'd0, 1'b0);
      run_vec(2'd3, s[0], 0, 32'h8123_4567, 1'b0, 2'd1, 1'b0);
      run_vec(2'd3, s[0], 0, 32'hC000_0100, 1'b0, 2'd0, 1'b0);
    end

    // sweep: boundaries of the subnormal range, unit range, overflow range
    for (int md = 0; md < 4; md++)
      for (int s = 0; s < 2; s++)
        for (int ufe = 0; ufe < 2; ufe++)
          for (int ei = 0; ei < 51; ei++)
            for (int k = 0; k < 12; k++)
              for (int stk = 0; stk < 2; stk++) begin
                int e;
                e = (ei < 41) ? -160 + ei : (ei < 46) ? ei - 43 : 124 + (ei - 46);
                run_vec(2'd1, s[0], e, pattern(k), stk[0], md[1:0], ufe[0]);
              end

    // pseudo-random vectors over all classes and the whole exponent range
    lfsr = 32'hACE1_2468;
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] m;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      m    = lfsr * 32'h9E37_79B9;
      run_vec((lfsr[3:2] == 2'd0) ? lfsr[5:4] : 2'd1, lfsr[6],
              int'($signed(lfsr[17:8])), {1'b1, m[30:0]}, lfsr[7], lfsr[19:18], lfsr[20]);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (WDOG) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule